// File: doc/BRIEF.md
# Counterflow Flush-Train Recovery Controller

This controller recovers an in-order pipeline from timing errors without stalling the whole pipeline at once. Each stage raises an error flag when its register captured a late value. The controller picks one failing stage and marks the slot after it as empty. In the next cycle it signals that the corrected value held on the side should re-enter the pipeline, so the failing instruction moves on with good inputs and does not run through the failing stage again.

After that it launches a flush token backward toward fetch, one stage per cycle. Each position the token visits invalidates its own stage and the stage just before it. Instructions move forward while the token moves back, so the two close on each other at twice the single rate, and two stages per step are needed. When the token has visited stage 0, the controller issues a one-cycle restart request. The restart address is the failing instruction's address plus one instruction size. Fetch is held off from detection until that request.

Stage 0 is the fetch end and stage N-1 is nearest writeback. Among errors in the same cycle, and between a new error and a running token, the stage with the higher index wins.

Top module: `flush_train_ctrl`

## Requirements
- R1: After reset, `kill`, `inject`, `fetch_hold` and `restart` are all zero.
- R2: An error counts only where both `stage_err[i]` and `stage_vld[i]` are 1. Among the counted errors of one cycle, the highest index h is selected. An error with its valid bit low has no effect on any output.
- R3: In the cycle an error at stage h is accepted, `kill[h+1]` is 1 in that same cycle. When h = N-1, no bubble bit is raised.
- R4: In the cycle after acceptance, `inject` equals exactly bit h. In every other cycle `inject` is zero.
- R5: The token sits at position h in the cycle after acceptance and moves down by one each cycle. While the token is at position p, `kill[p]` is 1, and `kill[p-1]` is also 1 when p > 0.
- R6: `restart` is a one-cycle pulse in the cycle after the token was at position 0, which is h+2 cycles after detection. In that cycle `restart_pc` equals the address of stage h at detection plus INSN_BYTES (4 by default).
- R7: `fetch_hold` is 1 from the detection cycle through the cycle before `restart`, and is 0 in the restart cycle unless a new error is accepted there.
- R8: While a token is active, an error at a stage with a higher index than the token's origin is accepted and replaces the token. Its bubble, inject, restart timing and restart address then follow R3 to R6. An error at an equal or lower index is ignored: it raises no bubble and does not change the kill pattern or the restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stage_err | input | N | Per-stage timing error flag |
| stage_vld | input | N | Per-stage slot-occupied flag |
| stage_pc | input | N*AW | Per-stage instruction address, stage i at bits [i*AW +: AW] |
| kill | output | N | Per-stage invalidate (bubble or flush) |
| inject | output | N | Per-stage select for re-entry of the corrected shadow value |
| fetch_hold | output | 1 | Holds fetch while a recovery is pending |
| restart | output | 1 | One-cycle restart request |
| restart_pc | output | AW | Address to restart fetch from |

## Verification
The assertions check these properties on every cycle:
- `inject` is never more than one-hot, and it follows a counted error.
- `restart` never lasts two cycles and is always preceded by a held fetch.
- Any counted error coincides with `fetch_hold`.

Only the directed scenarios can show the rest:
- the exact two-stage kill pattern as the token walks down,
- the restart falling h+2 cycles after detection with the right address,
- the higher-index stage winning among simultaneous errors,
- a later, higher error displacing a running token while a lower one leaves it untouched.

// File: rtl/flush_train_ctrl.sv
module flush_train_ctrl #(
  parameter int N          = 5,
  parameter int AW         = 32,
  parameter int INSN_BYTES = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    stage_err,
  input  logic [N-1:0]    stage_vld,
  input  logic [N*AW-1:0] stage_pc,
  output logic [N-1:0]    kill,
  output logic [N-1:0]    inject,
  output logic            fetch_hold,
  output logic            restart,
  output logic [AW-1:0]   restart_pc
);
  localparam int IDW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]   live;
  logic           hit;
  logic [IDW-1:0] hit_id;
  logic           accept;
  logic           tok_vld;
  logic [IDW-1:0] tok_pos;
  logic [IDW-1:0] tok_id;
  logic [N-1:0]   inj_q;
  logic           rst_q;
  logic [AW-1:0]  pc_q;

  assign live = stage_err & stage_vld;

  always_comb begin
    hit    = 1'b0;
    hit_id = '0;
    for (int i = 0; i < N; i++) begin
      if (live[i]) begin
        hit    = 1'b1;
        hit_id = IDW'(i);
      end
    end
  end

  assign accept = hit && (!tok_vld || (hit_id > tok_id));

  always_comb begin
    kill = '0;
    if (accept && (int'(hit_id) < N - 1))
      kill[int'(hit_id) + 1] = 1'b1;
    if (tok_vld) begin
      kill[tok_pos] = 1'b1;
      if (tok_pos != '0)
        kill[tok_pos - 1'b1] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tok_vld <= 1'b0;
      tok_pos <= '0;
      tok_id  <= '0;
      inj_q   <= '0;
      rst_q   <= 1'b0;
      pc_q    <= '0;
    end else if (accept) begin
      tok_vld <= 1'b1;
      tok_pos <= hit_id;
      tok_id  <= hit_id;
      inj_q   <= N'(1) << hit_id;
      rst_q   <= 1'b0;
      pc_q    <= stage_pc[int'(hit_id)*AW +: AW] + AW'(INSN_BYTES);
    end else begin
      inj_q <= '0;
      rst_q <= 1'b0;
      if (tok_vld) begin
        if (tok_pos == '0) begin
          tok_vld <= 1'b0;
          rst_q   <= 1'b1;
        end else begin
          tok_pos <= tok_pos - 1'b1;
        end
      end
    end
  end

  assign inject     = inj_q;
  assign restart    = rst_q;
  assign restart_pc = pc_q;
  assign fetch_hold = accept | tok_vld;
endmodule

module flush_train_ctrl_chk #(
  parameter int N  = 5,
  parameter int AW = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] stage_err,
  input logic [N-1:0] stage_vld,
  input logic [N-1:0] inject,
  input logic         fetch_hold,
  input logic         restart
);
  assert_inject_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(inject));

  assert_inject_after_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|inject) |-> $past(|(stage_err & stage_vld)));

  assert_restart_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !restart);

  assert_restart_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    restart |-> $past(fetch_hold));

  assert_err_holds_fetch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(stage_err & stage_vld)) |-> fetch_hold);
endmodule

bind flush_train_ctrl flush_train_ctrl_chk #(.N(N), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .stage_err(stage_err), .stage_vld(stage_vld),
  .inject(inject), .fetch_hold(fetch_hold), .restart(restart)
);

// File: tb/tb_flush_train_ctrl.sv
module tb_flush_train_ctrl;
  localparam int N  = 5;
  localparam int AW = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    stage_err = '0;
  logic [N-1:0]    stage_vld = '0;
  logic [N*AW-1:0] stage_pc = '0;
  logic [N-1:0]    kill, inject;
  logic            fetch_hold, restart;
  logic [AW-1:0]   restart_pc;

  int vectors = 0;
  int misses  = 0;
  logic [AW-1:0] base = '0;

  always #2.5 clk = ~clk;

  flush_train_ctrl #(.N(N), .AW(AW), .INSN_BYTES(4)) dut (
    .clk(clk), .rst_n(rst_n), .stage_err(stage_err), .stage_vld(stage_vld),
    .stage_pc(stage_pc), .kill(kill), .inject(inject), .fetch_hold(fetch_hold),
    .restart(restart), .restart_pc(restart_pc)
  );

  function automatic logic [N-1:0] tokmask(int p);
    logic [N-1:0] m = '0;
    m[p] = 1'b1;
    if (p > 0) m[p-1] = 1'b1;
    return m;
  endfunction

  function automatic logic [N-1:0] bubble(int h);
    logic [N-1:0] m = '0;
    if (h < N - 1) m[h+1] = 1'b1;
    return m;
  endfunction

  function automatic logic [AW-1:0] pc_of(int h);
    return base + AW'(h * 16);
  endfunction

  task automatic set_pcs(logic [AW-1:0] b);
    base = b;
    for (int i = 0; i < N; i++) stage_pc[i*AW +: AW] = pc_of(i);
  endtask

  task automatic cmp(string rq, string what, logic [AW-1:0] act, logic [AW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", rq, what, act, exp, $time);
    end
  endtask

  task automatic step(logic [N-1:0] e, logic [N-1:0] v, logic [N-1:0] ek,
                      logic [N-1:0] ei, logic eh, logic er, logic [AW-1:0] epc, string rq);
    @(negedge clk);
    stage_err = e;
    stage_vld = v;
    #1;
    cmp(rq, "kill", AW'(kill), AW'(ek));
    cmp(rq, "inject", AW'(inject), AW'(ei));
    cmp(rq, "fetch_hold", AW'(fetch_hold), AW'(eh));
    cmp(rq, "restart", AW'(restart), AW'(er));
    if (er) cmp(rq, "restart_pc", restart_pc, epc);
  endtask

  task automatic walk(int h, string rq);
    for (int p = h; p >= 0; p--)
      step('0, '1, tokmask(p), (p == h) ? N'(1) << h : '0, 1'b1, 1'b0, '0, rq);
    step('0, '1, '0, '0, 1'b0, 1'b1, pc_of(h) + 4, rq);
    step('0, '1, '0, '0, 1'b0, 1'b0, '0, rq);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    step('0, '0, '0, '0, 1'b0, 1'b0, '0, "R1");
  endtask

  task automatic t_single(int h, logic [AW-1:0] b);
    set_pcs(b);
    step(N'(1) << h, '1, bubble(h), '0, 1'b1, 1'b0, '0, "R3");
    walk(h, "R5_R6_R7");
  endtask

  task automatic t_invalid();
    step(N'(1) << 2, ~(N'(1) << 2), '0, '0, 1'b0, 1'b0, '0, "R2");
    step('0, '1, '0, '0, 1'b0, 1'b0, '0, "R2");
  endtask

  task automatic t_simultaneous();
    set_pcs(32'h0000_4000);
    step(5'b11010, 5'b01111, bubble(3), '0, 1'b1, 1'b0, '0, "R2");
    walk(3, "R2");
  endtask

  task automatic t_replace();
    set_pcs(32'h0008_0000);
    step(N'(1) << 1, '1, bubble(1), '0, 1'b1, 1'b0, '0, "R8");
    step(N'(1) << 3, '1, tokmask(1) | bubble(3), N'(1) << 1, 1'b1, 1'b0, '0, "R8");
    walk(3, "R8");
  endtask

  task automatic t_ignore_lower();
    set_pcs(32'hC000_0100);
    step(N'(1) << 4, '1, '0, '0, 1'b1, 1'b0, '0, "R8");
    step(N'(1) << 1, '1, tokmask(4), N'(1) << 4, 1'b1, 1'b0, '0, "R8");
    step(N'(1) << 3, '1, tokmask(3), '0, 1'b1, 1'b0, '0, "R8");
    for (int p = 2; p >= 0; p--)
      step('0, '1, tokmask(p), '0, 1'b1, 1'b0, '0, "R8");
    step('0, '1, '0, '0, 1'b0, 1'b1, pc_of(4) + 4, "R8");
    step('0, '1, '0, '0, 1'b0, 1'b0, '0, "R6");
  endtask

  initial begin
    t_reset();
    t_single(2, 32'h0000_1000);
    t_single(N - 1, 32'h1234_0000);
    t_single(0, 32'hFFFF_FF00);
    t_invalid();
    t_simultaneous();
    t_replace();
    t_ignore_lower();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #1000000;
    misses++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule